// File: doc/BRIEF.md
# USB Common Interrupt Status Latch

This block holds the eight common-event interrupt flags of a dual-role USB controller. The bus-state logic sends it single-cycle event pulses: VBus falling too low, a session request, a disconnect, a session end, a connect, a frame start, reset signalling, babble, resume and suspend. Three role inputs describe the controller's present state: host or peripheral, A-device or B-device, and suspended or not. The role inputs decide which pulses may set a flag. For two flags they also decide which event the flag stands for.

Each flag stays set until software reads the register. A read strobe returns all eight flags and clears them in the same access. The combined interrupt request is the OR of the flags after each one is ANDed with an enable mask. The mask only gates the request line. Masked flags still set and can still be read.

Top module: `usb_irq_latch`

## Requirements
- R1: After reset all eight status bits read 0 and `irq` is low.
- R2: While `rd_stb` is high, `rd_data` presents the status bits. After that cycle every bit reads 0 unless an event set it during the read cycle.
- R3: An event that arrives in the same cycle as a read does not appear in that read's data. It stays latched and is returned by the next read.
- R4: Bit 7 (VBus error) sets on `ev_vbus_low` and bit 6 (session request) sets on `ev_sess_req`, but only while `is_a_dev` is 1.
- R5: Bit 5 (disconnect) sets on `ev_disconnect` when `is_host` is 1 and on `ev_sess_end` when `is_host` is 0. The other pulse of the pair is ignored in each role.
- R6: Bit 4 (connect) sets on `ev_connect` only while `is_host` is 1.
- R7: Bit 3 (frame start) sets on `ev_frame` in every role.
- R8: Bit 2 (reset/babble) sets on `ev_reset_sig` when `is_host` is 0 and on `ev_babble` when `is_host` is 1. The other pulse of the pair is ignored in each role.
- R9: Bit 1 (resume) sets on `ev_resume` only while `suspended` is 1.
- R10: Bit 0 (suspend) sets on `ev_suspend` only while `is_host` is 0.
- R11: A set bit stays set over any number of cycles without a read.
- R12: `irq` is high exactly when some status bit and the matching `irq_mask` bit are both 1. The mask has no effect on which bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_host | input | 1 | 1 = host role, 0 = peripheral role |
| is_a_dev | input | 1 | 1 = controller is the A-device |
| suspended | input | 1 | 1 = controller is in suspend |
| ev_vbus_low | input | 1 | VBus fell below the valid level during a session |
| ev_sess_req | input | 1 | Session request signalling detected |
| ev_disconnect | input | 1 | Device disconnect detected |
| ev_sess_end | input | 1 | Session ended |
| ev_connect | input | 1 | Device connection detected |
| ev_frame | input | 1 | New frame started |
| ev_reset_sig | input | 1 | Bus reset signalling detected |
| ev_babble | input | 1 | Babble detected |
| ev_resume | input | 1 | Resume signalling detected |
| ev_suspend | input | 1 | Suspend signalling detected |
| rd_stb | input | 1 | Read strobe: returns the status and clears it |
| rd_data | output | 8 | Status bits |
| irq_mask | input | 8 | Per-bit interrupt enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that the role gating holds. A connect flag cannot appear while the controller is a peripheral. The suspend flag cannot appear while it is a host. The A-device flags cannot appear on a B-device, and the resume flag cannot appear while the controller is not suspended. They also check that flags persist when there is no read, that a frame pulse is never lost (even during a read), that a read with no events leaves zero, and that a zero mask keeps the request low.

Only the bench's scenarios show the remaining behaviour. That covers which of the paired pulses drives the disconnect and reset/babble flags in each role, and the exact value a read returns when an event coincides with it. It also covers the request line following individual mask bits, and the full multi-event pattern.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int STAT_W = 8;

    localparam int B_VBUS  = 7;
    localparam int B_SREQ  = 6;
    localparam int B_DISC  = 5;
    localparam int B_CONN  = 4;
    localparam int B_FRAME = 3;
    localparam int B_RSTBB = 2;
    localparam int B_RESUM = 1;
    localparam int B_SUSP  = 0;

    typedef struct packed {
        logic host;
        logic a_dev;
        logic susp;
    } role_t;

    typedef struct packed {
        logic vbus_low;
        logic sess_req;
        logic disconnect;
        logic sess_end;
        logic connect;
        logic frame;
        logic reset_sig;
        logic babble;
        logic resume;
        logic suspend;
    } bus_evt_t;

    typedef struct packed {
        logic [STAT_W-1:0] flags;
    } stat_state_t;
endpackage

// File: rtl/usb_irq_qual.sv
module usb_irq_qual
    import usb_irq_pkg::*;
(
    input  role_t              role,
    input  bus_evt_t           evt,
    output logic [STAT_W-1:0]  set_vec
);
    always_comb begin
        set_vec          = '0;
        set_vec[B_VBUS]  = evt.vbus_low & role.a_dev;
        set_vec[B_SREQ]  = evt.sess_req & role.a_dev;
        set_vec[B_DISC]  = role.host ? evt.disconnect : evt.sess_end;
        set_vec[B_CONN]  = evt.connect & role.host;
        set_vec[B_FRAME] = evt.frame;
        set_vec[B_RSTBB] = role.host ? evt.babble : evt.reset_sig;
        set_vec[B_RESUM] = evt.resume & role.susp;
        set_vec[B_SUSP]  = evt.suspend & ~role.host;
    end
endmodule

// File: rtl/usb_irq_stat.sv
module usb_irq_stat
    import usb_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STAT_W-1:0]  set_vec,
    input  logic               rd_stb,
    output logic [STAT_W-1:0]  flags
);
    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_stb) st_d.flags = set_vec;
        else        st_d.flags = st_q.flags | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ((flags & $past(flags)) == $past(flags)));

    assert_quiet_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && set_vec == '0) |=> (flags == '0));

    assert_no_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[B_FRAME] |=> flags[B_FRAME]);
endmodule

// File: rtl/usb_irq_req.sv
module usb_irq_req #(
    parameter int W = 8
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] mask,
    output logic         irq
);
    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign hit[i] = flags[i] & mask[i];
    end

    assign irq = |hit;

    always_comb begin
        if (mask == '0) assert_masked_quiet_R12: assert (!irq);
    end
endmodule

// File: rtl/usb_irq_latch.sv
module usb_irq_latch
    import usb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_host,
    input  logic              is_a_dev,
    input  logic              suspended,
    input  logic              ev_vbus_low,
    input  logic              ev_sess_req,
    input  logic              ev_disconnect,
    input  logic              ev_sess_end,
    input  logic              ev_connect,
    input  logic              ev_frame,
    input  logic              ev_reset_sig,
    input  logic              ev_babble,
    input  logic              ev_resume,
    input  logic              ev_suspend,
    input  logic              rd_stb,
    output logic [STAT_W-1:0] rd_data,
    input  logic [STAT_W-1:0] irq_mask,
    output logic              irq
);
    role_t             role;
    bus_evt_t          evt;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] flags;

    assign role = '{host: is_host, a_dev: is_a_dev, susp: suspended};
    assign evt  = '{vbus_low: ev_vbus_low, sess_req: ev_sess_req,
                    disconnect: ev_disconnect, sess_end: ev_sess_end,
                    connect: ev_connect, frame: ev_frame,
                    reset_sig: ev_reset_sig, babble: ev_babble,
                    resume: ev_resume, suspend: ev_suspend};

    usb_irq_qual u_qual (.role(role), .evt(evt), .set_vec(set_vec));

    usb_irq_stat u_stat (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .rd_stb(rd_stb), .flags(flags)
    );

    usb_irq_req #(.W(STAT_W)) u_req (.flags(flags), .mask(irq_mask), .irq(irq));

    assign rd_data = flags;

    assert_conn_host_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_host && !rd_data[B_CONN]) |=> !rd_data[B_CONN]);

    assert_susp_periph_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_host && !rd_data[B_SUSP]) |=> !rd_data[B_SUSP]);

    assert_vbus_a_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_a_dev && !rd_data[B_VBUS]) |=> !rd_data[B_VBUS]);

    assert_sreq_a_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_a_dev && !rd_data[B_SREQ]) |=> !rd_data[B_SREQ]);

    assert_resume_susp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspended && !rd_data[B_RESUM]) |=> !rd_data[B_RESUM]);

    assert_irq_needs_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_data != '0));
endmodule

// File: tb/tb_usb_irq_latch.sv
module tb_usb_irq_latch;
    logic clk = 0;
    logic rst_n = 0;
    logic is_host = 0, is_a_dev = 0, suspended = 0;
    logic [9:0] evs = '0;
    logic rd_stb = 0;
    logic [7:0] irq_mask = '0;
    logic [7:0] rd_data;
    logic irq;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    usb_irq_latch dut (
        .clk(clk), .rst_n(rst_n), .is_host(is_host), .is_a_dev(is_a_dev),
        .suspended(suspended),
        .ev_vbus_low(evs[0]), .ev_sess_req(evs[1]), .ev_disconnect(evs[2]),
        .ev_sess_end(evs[3]), .ev_connect(evs[4]), .ev_frame(evs[5]),
        .ev_reset_sig(evs[6]), .ev_babble(evs[7]), .ev_resume(evs[8]),
        .ev_suspend(evs[9]),
        .rd_stb(rd_stb), .rd_data(rd_data), .irq_mask(irq_mask), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare every read against the scoreboard queue
    always @(negedge clk) begin
        if (rd_stb && rst_n) begin
            if (exp_q.size() == 0) chk(0, "R2 unexpected read", rd_data, 8'h00);
            else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rd_data === e, t, rd_data, e);
            end
        end
    end

    task automatic pulse(input logic [9:0] v);
        @(posedge clk); #1 evs = v;
        @(posedge clk); #1 evs = '0;
    endtask

    task automatic rd(input logic [7:0] exp, input string tag, input logic [9:0] v = '0);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1 rd_stb = 1; evs = v;
        @(posedge clk); #1 rd_stb = 0; evs = '0;
    endtask

    task automatic role(input logic h, input logic a, input logic s);
        @(posedge clk); #1 is_host = h; is_a_dev = a; suspended = s;
    endtask

    task automatic one(input logic [9:0] v, input logic [7:0] exp, input string tag);
        pulse(v);
        rd(exp, tag);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(rd_data === 8'h00, "R1 reset status", rd_data, 8'h00);
        chk(irq === 1'b0, "R1 reset irq", {7'b0, irq}, 8'h00);

        // R4: B-device ignores VBus and session request
        role(0, 0, 0);
        one(10'h001, 8'h00, "R4 vbus on B-device");
        one(10'h002, 8'h00, "R4 sreq on B-device");
        role(0, 1, 0);
        one(10'h001, 8'h80, "R4 vbus on A-device");
        one(10'h002, 8'h40, "R4 sreq on A-device");

        // R5: disconnect meaning by role
        role(1, 0, 0);
        one(10'h004, 8'h20, "R5 host disconnect");
        one(10'h008, 8'h00, "R5 host ignores session end");
        role(0, 0, 0);
        one(10'h008, 8'h20, "R5 peripheral session end");
        one(10'h004, 8'h00, "R5 peripheral ignores disconnect");

        // R6
        role(1, 0, 0);
        one(10'h010, 8'h10, "R6 host connect");
        role(0, 0, 0);
        one(10'h010, 8'h00, "R6 peripheral connect ignored");

        // R7
        one(10'h020, 8'h08, "R7 frame peripheral");
        role(1, 1, 0);
        one(10'h020, 8'h08, "R7 frame host");

        // R8
        role(0, 0, 0);
        one(10'h040, 8'h04, "R8 peripheral reset");
        one(10'h080, 8'h00, "R8 peripheral ignores babble");
        role(1, 0, 0);
        one(10'h080, 8'h04, "R8 host babble");
        one(10'h040, 8'h00, "R8 host ignores reset");

        // R9
        role(0, 0, 1);
        one(10'h100, 8'h02, "R9 resume while suspended");
        role(0, 0, 0);
        one(10'h100, 8'h00, "R9 resume while awake");

        // R10
        one(10'h200, 8'h01, "R10 suspend peripheral");
        role(1, 0, 0);
        one(10'h200, 8'h00, "R10 suspend host ignored");

        // all events at once, host A-device suspended
        role(1, 1, 1);
        one(10'h3FF, 8'hFE, "R4 R5 R6 R7 R8 R9 all events host");
        rd(8'h00, "R2 cleared after read");

        // R11 sticky
        role(0, 0, 0);
        pulse(10'h020);
        pulse(10'h200);
        repeat (6) @(posedge clk);
        rd(8'h09, "R11 sticky bits");

        // R3 event during read
        pulse(10'h200);
        rd(8'h01, "R3 read returns old value", 10'h020);
        rd(8'h08, "R3 coincident event kept");
        rd(8'h00, "R3 cleared afterwards");

        // R12 irq masking
        irq_mask = 8'h00;
        pulse(10'h020);
        @(negedge clk);
        chk(irq === 1'b0, "R12 mask zero irq low", {7'b0, irq}, 8'h00);
        #1 irq_mask = 8'hF7;
        @(negedge clk);
        chk(irq === 1'b0, "R12 other bits enabled irq low", {7'b0, irq}, 8'h00);
        #1 irq_mask = 8'h08;
        @(negedge clk);
        chk(irq === 1'b1, "R12 matching enable irq high", {7'b0, irq}, 8'h01);
        rd(8'h08, "R12 masked bit still latched");
        @(negedge clk);
        chk(irq === 1'b0, "R12 irq low after read", {7'b0, irq}, 8'h00);

        repeat (3) @(posedge clk);
        @(negedge clk);
        if (exp_q.size() != 0) chk(0, "R2 reads missing", 8'(exp_q.size()), 8'h00);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule